// File: doc/BRIEF.md
# Two-Bit Burst Address Generator

This block produces the access address for a synchronous burst memory. At the start of a burst it registers a full address from an external bus; on the following cycles it supplies that address with the two least significant bits replaced by a beat counter, so that a four-beat burst can be served from a single address transfer. The upper bits stay fixed for the whole burst.

A burst begins when either of two active-low start strobes is sampled low. One strobe is meant for a processor-side requester and one for a memory-controller requester; inside this block they behave the same. After the start, each cycle with the active-low advance strobe low steps the counter by one beat. A cycle with advance high suspends the burst and holds the address. The counter is driven only by the strobes and not by the direction or output enable of the access, so a read whose data is never driven still moves the burst forward.

A static order-select input picks how the low bits walk through the burst. When it is low the low bits count upward from the start value and wrap modulo four. When it is high the low bits are the start value XOR a beat index running 0, 1, 2, 3. High (interleaved) is the order to use when the system does not choose.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the registered address, start value and beat index clear, so `addr_out` reads all zeros after that edge.
- R2: When `ld_host_n` or `ld_ctrl_n` (or both) is low at a rising edge, `addr_out` equals the value of `addr_in` sampled at that edge from the next cycle on, in both orders.
- R3: With `order_sel` low (linear order), after n advances since the last start the low two bits of `addr_out` equal (start + n) modulo 4; a start of 01 gives 01, 10, 11, 00.
- R4: With `order_sel` high (interleaved order), after n advances the low two bits equal start XOR (n modulo 4); a start of 01 gives 01, 00, 11, 10.
- R5: After four advances since a start the low two bits return to the start value, in either order.
- R6: A cycle with `adv_n` high and both start strobes high leaves `addr_out` unchanged.
- R7: A start strobe low at the same edge as `adv_n` low loads the new address and does not advance; the next cycle shows beat zero of the new burst.
- R8: Bits above the low two of `addr_out` change only at an edge where a start strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_in | input | ADDR_W | External address captured at a burst start |
| ld_host_n | input | 1 | Processor-side burst start, active low |
| ld_ctrl_n | input | 1 | Controller-side burst start, active low |
| adv_n | input | 1 | Advance to next beat, active low |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_out | output | ADDR_W | Current access address |

## Verification
The assertions take for granted that every input carries a known 0 or 1 at each rising edge and that the reset is held for at least one edge before the first burst. The hold and upper-bit properties look only at registered state, so `order_sel` may change at any time without breaking them, and the stimulus exercises this by toggling the order mid-burst now and then. The random phase draws start strobes, advance and address from a seeded generator and the directed cases cover both example sequences, the wrap on the fifth beat, suspension, and a start coinciding with an advance.

// File: rtl/bag_pkg.sv
// Package: shared types and helpers for the burst address generator.
// Assumes the beat counter is narrow (a few bits); helpers are pure.
package bag_pkg;

    // Order of the low address bits through a burst.
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

    // Default width of the beat counter (four-beat burst).
    localparam int unsigned BAG_BEAT_W = 2;

endpackage : bag_pkg

// File: rtl/bag_addr_capture.sv
// Module: holds the upper address bits and the burst start value.
// Captures addr_in whenever a start is requested; otherwise holds.
// Assumes load is already the OR of both start strobes.
module bag_addr_capture #(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned BEAT_W = 2,
    localparam int unsigned HI_W  = ADDR_W - BEAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [HI_W-1:0]   hi_q,
    output logic [BEAT_W-1:0] start_q
);

    // Address register: reset, capture on load, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= '0;
            start_q <= '0;
        end else if (load) begin
            hi_q    <= addr_in[ADDR_W-1:BEAT_W];
            start_q <= addr_in[BEAT_W-1:0];
        end
    end

    AST_START_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(start_q) && $stable(hi_q)); // R8

endmodule : bag_addr_capture

// File: rtl/bag_beat_counter.sv
// Module: beat index of the current burst, independent of the start value.
// Clears on a start, steps modulo 2**BEAT_W on an advance, holds otherwise.
// Assumes load and advance are decoded by the parent; load wins.
module bag_beat_counter #(
    parameter int unsigned BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    output logic [BEAT_W-1:0] idx_q
);

    localparam logic [BEAT_W-1:0] LAST_BEAT = {BEAT_W{1'b1}};

    logic step;

    // Step only when advancing without a start in the same cycle.
    always_comb step = advance && !load;

    // Beat index register with natural modulo wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (load) begin
            idx_q <= '0;
        end else if (step) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    AST_ADVANCE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> idx_q == BEAT_W'($past(idx_q) + 1'b1)); // R3
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (step && idx_q == LAST_BEAT) |=> idx_q == '0); // R5
    AST_HOLD_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !load) |=> $stable(idx_q)); // R6
    AST_LOAD_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (load && advance) |=> idx_q == '0); // R7

endmodule : bag_beat_counter

// File: rtl/bag_order_map.sv
// Module: combinational map from start value and beat index to low bits.
// Linear order adds the index; interleaved order XORs it per bit.
// Assumes order is quasi-static; no state here.
module bag_order_map
    import bag_pkg::*;
#(
    parameter int unsigned BEAT_W = 2
) (
    input  logic              order,
    input  logic [BEAT_W-1:0] start,
    input  logic [BEAT_W-1:0] idx,
    output logic [BEAT_W-1:0] low
);

    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] ilv_low;

    // Linear order: start plus index, wrapping modulo 2**BEAT_W.
    always_comb lin_low = start + idx;

    // Interleaved order: one XOR gate per counter bit.
    for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
        assign ilv_low[b] = start[b] ^ idx[b];
    end

    // Select the order requested by the mode input.
    always_comb low = (burst_order_e'(order) == ORD_INTERLEAVE) ? ilv_low : lin_low;

endmodule : bag_order_map

// File: rtl/burst_addr_gen.sv
// Module: top of the burst address generator.
// Decodes the active-low strobes, registers the start address and beat
// index, and forms addr_out from the upper bits and the mapped low bits.
// Assumes all inputs are synchronous to clk; order_sel is a mode setting.
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned BEAT_W = BAG_BEAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ld_host_n,
    input  logic              ld_ctrl_n,
    input  logic              adv_n,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] addr_out
);

    localparam int unsigned HI_W = ADDR_W - BEAT_W;

    logic              load;
    logic              advance;
    logic [HI_W-1:0]   hi_q;
    logic [BEAT_W-1:0] start_q;
    logic [BEAT_W-1:0] idx_q;
    logic [BEAT_W-1:0] low;

    // Strobe decode: either start strobe loads; advance is active low.
    always_comb begin
        load    = !ld_host_n || !ld_ctrl_n;
        advance = !adv_n;
    end

    bag_addr_capture #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .addr_in (addr_in),
        .hi_q    (hi_q),
        .start_q (start_q)
    );

    bag_beat_counter #(.BEAT_W(BEAT_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .advance (advance),
        .idx_q   (idx_q)
    );

    bag_order_map #(.BEAT_W(BEAT_W)) u_map (
        .order (order_sel),
        .start (start_q),
        .idx   (idx_q),
        .low   (low)
    );

    // Output address: fixed upper bits with the burst low bits.
    always_comb addr_out = {hi_q, low};

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> addr_out == $past(addr_in)); // R2
    AST_UPPER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(addr_out[ADDR_W-1:BEAT_W])); // R8
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> addr_out == '0 || !rst_n); // R1

endmodule : burst_addr_gen

// File: tb/burst_addr_gen_bench.sv
// Bench: directed corner cases plus seeded random stimulus, checked
// against a model of start value, beat index and upper bits.
module burst_addr_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 19;
    localparam int RAND_CYCLES = 3000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          ld_host_n = 1'b1;
    logic          ld_ctrl_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          order_sel = 1'b1;
    logic [AW-1:0] addr_out;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    // Model state
    logic [AW-3:0] m_hi = '0;
    logic [1:0]    m_start = '0;
    logic [1:0]    m_idx = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_gen u_burst_addr_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_in   (addr_in),
        .ld_host_n (ld_host_n),
        .ld_ctrl_n (ld_ctrl_n),
        .adv_n     (adv_n),
        .order_sel (order_sel),
        .addr_out  (addr_out)
    );

    function automatic logic [1:0] exp_low(logic [1:0] s, logic [1:0] i, logic ord);
        return ord ? (s ^ i) : 2'(s + i);
    endfunction

    function automatic logic [AW-1:0] exp_addr();
        return {m_hi, exp_low(m_start, m_idx, order_sel)};
    endfunction

    task automatic check(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle at a falling edge, advance the model, wait one cycle.
    task automatic cyc(bit lh, bit lc, bit av, bit ord, logic [AW-1:0] a);
        ld_host_n = lh;
        ld_ctrl_n = lc;
        adv_n     = av;
        order_sel = ord;
        addr_in   = a;
        if (!lh || !lc) begin
            m_hi    = a[AW-1:2];
            m_start = a[1:0];
            m_idx   = 2'd0;
        end else if (!av) begin
            m_idx = m_idx + 2'd1;
        end
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] base;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset", addr_out, '0);

        // R3 linear, start 01: 01,10,11,00 then R5 wrap to 01
        base = 19'h2A5A1;
        cyc(0, 1, 1, 0, base);
        check("R2 host load", addr_out, base);
        cyc(1, 1, 0, 0, '0); check("R3 beat1", addr_out, {base[AW-1:2], 2'b10});
        cyc(1, 1, 0, 0, '0); check("R3 beat2", addr_out, {base[AW-1:2], 2'b11});
        cyc(1, 1, 0, 0, '0); check("R3 beat3", addr_out, {base[AW-1:2], 2'b00});
        cyc(1, 1, 0, 0, '0); check("R5 linear wrap", addr_out, base);

        // R4 interleaved, start 01: 01,00,11,10 then wrap
        base = 19'h13375;
        cyc(1, 0, 1, 1, base);
        check("R2 ctrl load", addr_out, base);
        cyc(1, 1, 0, 1, '0); check("R4 beat1", addr_out, {base[AW-1:2], 2'b00});
        cyc(1, 1, 0, 1, '0); check("R4 beat2", addr_out, {base[AW-1:2], 2'b11});
        // R6 suspend
        cyc(1, 1, 1, 1, 19'h7FFFF); check("R6 hold", addr_out, {base[AW-1:2], 2'b11});
        cyc(1, 1, 1, 1, 19'h00000); check("R6 hold again", addr_out, {base[AW-1:2], 2'b11});
        cyc(1, 1, 0, 1, '0); check("R4 beat3", addr_out, {base[AW-1:2], 2'b10});
        cyc(1, 1, 0, 1, '0); check("R5 interleave wrap", addr_out, base);
        check("R8 upper bits", {addr_out[AW-1:2], 2'b00}, {base[AW-1:2], 2'b00});

        // R7 load with advance low, both strobes low
        base = 19'h40002;
        cyc(0, 0, 0, 1, base); check("R7 load beats advance", addr_out, base);
        cyc(1, 1, 0, 1, '0);   check("R7 then step", addr_out, {base[AW-1:2], 2'b11});

        // Random phase
        for (int k = 0; k < RAND_CYCLES; k++) begin
            int r;
            bit lh, lc, av, ord;
            string tag;
            r   = int'($urandom % 16);
            lh  = (r != 0);
            lc  = (r != 1);
            av  = ($urandom % 3) == 0;
            ord = (($urandom % 32) == 0) ? ~order_sel : order_sel;
            if (!lh || !lc)  tag = "R2 rand load";
            else if (av)     tag = "R6 rand hold";
            else if (ord)    tag = "R4 rand step";
            else             tag = "R3 rand step";
            cyc(lh, lc, av, ord, AW'($urandom));
            check(tag, addr_out, exp_addr());
        end

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule : burst_addr_gen_bench